// File: doc/BRIEF.md
# Coarse-Grain Thread Switch Controller

This controller arbitrates ownership of a single in-order pipeline between two hardware thread contexts. One context is fixed by parameter as the favoured thread. It keeps the pipeline whenever it is not waiting on a long-latency memory miss. When the running context reports a miss, the controller gives the pipeline to the other context. The pipeline is not partitioned, so every handover empties it first: the controller raises a flush window, switches the register-file select and the thread ID, and then issues a single fetch redirect to the PC at which the incoming context must resume.

The surrounding core reports two kinds of events, each tagged with a one-bit thread ID: the start of a miss and the return of a miss. It also presents the PC of the oldest unretired instruction of the running thread. That PC is captured as the outgoing thread's restart point whenever a switch is taken. When the favoured thread's miss returns, control goes back to it. When both contexts are waiting, fetch stalls in place and no switch is made.

Top module: `cgmt_switch_ctrl`

## Requirements
- R1: After reset, `active_tid` equals the favoured thread (parameter PREF_TID, default 0), `rf_sel` is one-hot with bit i set when thread i is active, and `flush`, `redirect_valid` and `fetch_stall` are 0.
- R2: A miss-start event for the running favoured thread, sampled at edge k, causes `active_tid` to change to the other thread and `flush` to rise after edge k+1, provided the other thread is not blocked.
- R3: `flush` stays high for exactly FLUSH_CYCLES consecutive cycles, and `fetch_stall` is high throughout. In the cycle right after the window, `redirect_valid` is high for one cycle. `flush` and `redirect_valid` are never high together.
- R4: On every switch, the `oldest_pc` value present at the switching edge is stored as the outgoing thread's restart PC. When that thread is next switched in, this value appears on `redirect_pc` during the redirect cycle. Before a thread's first switch-out, its restart PC is BOOT_PC0 or BOOT_PC1.
- R5: When the favoured thread's miss returns while the other thread runs, a switch back to the favoured thread starts in the same way as R2, with the same latency.
- R6: While both threads are blocked, `flush` stays low, `active_tid` does not change and `fetch_stall` is high. The first miss return that follows starts a switch to the returning thread if that thread is not the one currently running.
- R7: A miss-start event tagged with the thread that is not running causes no switch and no flush. It only marks that thread as blocked. This is observed at the ports: a later miss on the running thread produces a stall instead of a switch.
- R8: A condition that calls for a switch while a flush is in progress is held back. The new flush begins in the cycle that follows the redirect cycle ending the current window.
- R9: `rf_sel` always selects the register file of `active_tid`, and `active_tid` changes only on the edge where a flush window opens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_start_valid | input | 1 | A long-latency miss has begun |
| miss_start_tid | input | 1 | Thread that took the miss |
| miss_ret_valid | input | 1 | An outstanding miss has completed |
| miss_ret_tid | input | 1 | Thread whose miss completed |
| oldest_pc | input | PC_W | PC of the oldest unretired instruction of the running thread |
| active_tid | output | 1 | Thread that currently owns the pipeline |
| rf_sel | output | 2 | One-hot register-file select, bit i for thread i |
| flush | output | 1 | Pipeline flush window |
| fetch_stall | output | 1 | Fetch must not issue (flush window or running thread blocked) |
| redirect_valid | output | 1 | One-cycle fetch redirect |
| redirect_pc | output | PC_W | Restart PC of the active thread, meaningful with redirect_valid |

## Verification
Two functions can coincide in one cycle: the end of a flush window with its redirect, and a switch that was held back during that window. The bench provokes this by sending a miss return for the favoured thread while the flush away from it is still running. It then checks that the first window lasts its full length and ends in a redirect to the other thread's restart PC, that a second window opens in the very next cycle, and that the second redirect carries the PC saved when the favoured thread left.

// File: rtl/cgmt_switch_ctrl.sv
module cgmt_switch_ctrl #(
  parameter int              PC_W         = 32,
  parameter int              FLUSH_CYCLES = 4,
  parameter bit              PREF_TID     = 1'b0,
  parameter logic [PC_W-1:0] BOOT_PC0     = PC_W'('h1000),
  parameter logic [PC_W-1:0] BOOT_PC1     = PC_W'('h2000)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            miss_start_valid,
  input  logic            miss_start_tid,
  input  logic            miss_ret_valid,
  input  logic            miss_ret_tid,
  input  logic [PC_W-1:0] oldest_pc,
  output logic            active_tid,
  output logic [1:0]      rf_sel,
  output logic            flush,
  output logic            fetch_stall,
  output logic            redirect_valid,
  output logic [PC_W-1:0] redirect_pc
);

  localparam int CNT_W = (FLUSH_CYCLES > 1) ? $clog2(FLUSH_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FLUSH_CYCLES - 1);

  logic [1:0]       blocked, blocked_nxt;
  logic             act, flushing, redir;
  logic [CNT_W-1:0] cnt;
  logic [PC_W-1:0]  restart_pc [2];
  logic             target, target_ok, sw_req;

  always_comb begin
    blocked_nxt = blocked;
    if (miss_ret_valid)   blocked_nxt[miss_ret_tid]   = 1'b0;
    if (miss_start_valid) blocked_nxt[miss_start_tid] = 1'b1;
  end

  assign target_ok = ~&blocked;
  assign target    = blocked[PREF_TID] ? ~PREF_TID : PREF_TID;
  assign sw_req    = !flushing && target_ok && (target != act);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blocked       <= 2'b00;
      act           <= PREF_TID;
      flushing      <= 1'b0;
      redir         <= 1'b0;
      cnt           <= '0;
      restart_pc[0] <= BOOT_PC0;
      restart_pc[1] <= BOOT_PC1;
    end else begin
      blocked <= blocked_nxt;
      redir   <= 1'b0;
      if (sw_req) begin
        restart_pc[act] <= oldest_pc;
        act             <= target;
        flushing        <= 1'b1;
        cnt             <= CNT_LAST;
      end else if (flushing) begin
        if (cnt == '0) begin
          flushing <= 1'b0;
          redir    <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  assign active_tid     = act;
  assign rf_sel         = {act, ~act};
  assign flush          = flushing;
  assign fetch_stall    = flushing | blocked[act];
  assign redirect_valid = redir;
  assign redirect_pc    = restart_pc[act];

  a_r3_redirect_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> $past(flush));

  a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(flush && redirect_valid));

  a_r9_switch_opens_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (active_tid != $past(active_tid)) |-> (flush && !$past(flush)));

  a_r6_hold_when_both_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (&blocked && !flush) |=> (!flush && $stable(active_tid)));

  a_r5_return_to_pref: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !blocked[PREF_TID] && active_tid != PREF_TID) |=>
      (flush && active_tid == PREF_TID));

  a_r7_idle_miss_no_switch: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_start_valid && miss_start_tid != active_tid && active_tid == PREF_TID &&
     !miss_ret_valid && !flush && !blocked[active_tid]) |=> !flush);

endmodule

// File: tb/cgmt_switch_ctrl_tb.sv
`timescale 1ns/1ps
module cgmt_switch_ctrl_tb;
  localparam int PC_W = 32;
  localparam int FC   = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ms_v = 0, ms_t = 0, mr_v = 0, mr_t = 0;
  logic [PC_W-1:0] opc = '0;
  logic act, fl, stall, rv;
  logic [1:0] sel;
  logic [PC_W-1:0] rpc;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cgmt_switch_ctrl #(.PC_W(PC_W), .FLUSH_CYCLES(FC), .PREF_TID(1'b0),
    .BOOT_PC0(32'h1000), .BOOT_PC1(32'h2000)) u_dut (
    .clk(clk), .rst_n(rst_n), .miss_start_valid(ms_v), .miss_start_tid(ms_t),
    .miss_ret_valid(mr_v), .miss_ret_tid(mr_t), .oldest_pc(opc),
    .active_tid(act), .rf_sel(sel), .flush(fl), .fetch_stall(stall),
    .redirect_valid(rv), .redirect_pc(rpc));

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic pulse_start(input logic t);
    ms_v = 1; ms_t = t; @(negedge clk); ms_v = 0;
  endtask

  task automatic pulse_ret(input logic t);
    mr_v = 1; mr_t = t; @(negedge clk); mr_v = 0;
  endtask

  // Called one negedge after the triggering event; checks the whole switch.
  task automatic expect_switch(input logic exp_tid, input logic [PC_W-1:0] exp_pc,
                               input string req);
    int n;
    check(!fl, req, "no flush before decision edge", fl, 0);
    @(negedge clk);
    check(fl && act == exp_tid, req, "flush open / new active", {fl, act}, {1'b1, exp_tid});
    check(sel == (exp_tid ? 2'b10 : 2'b01), "R9", "rf_sel", sel, exp_tid ? 2'b10 : 2'b01);
    n = 0;
    for (int i = 0; i < 50 && fl; i++) begin
      check(stall && !rv, "R3", "stall high, no redirect in window", {stall, rv}, 2'b10);
      n++;
      @(negedge clk);
    end
    check(n == FC, "R3", "flush length", n, FC);
    check(rv, "R3", "redirect after window", rv, 1);
    check(rpc == exp_pc, "R4", "redirect pc", rpc, exp_pc);
  endtask

  task automatic t_reset();
    check(act == 0 && sel == 2'b01, "R1", "active/sel after reset", {act, sel}, 3'b001);
    check(!fl && !rv && !stall, "R1", "flush/redirect/stall after reset", {fl, rv, stall}, 0);
  endtask

  task automatic t_switch_away();
    opc = 32'h1234;
    pulse_start(0);
    expect_switch(1, 32'h2000, "R2");
    @(negedge clk);
    check(!rv && !stall, "R3", "redirect is one cycle", {rv, stall}, 0);
  endtask

  task automatic t_switch_back();
    opc = 32'h2468;
    pulse_ret(0);
    expect_switch(0, 32'h1234, "R5");
    @(negedge clk);
  endtask

  task automatic t_idle_miss_and_both_blocked();
    pulse_start(1);
    for (int i = 0; i < 4; i++) begin
      check(!fl && act == 0 && !stall, "R7", "idle-thread miss ignored", {fl, act, stall}, 0);
      @(negedge clk);
    end
    opc = 32'h1800;
    pulse_start(0);
    for (int i = 0; i < 6; i++) begin
      check(!fl && act == 0 && stall, "R6", "both blocked: hold and stall", {fl, act, stall}, 3'b001);
      @(negedge clk);
    end
    pulse_ret(1);
    expect_switch(1, 32'h2468, "R6");
    @(negedge clk);
    opc = 32'h2800;
    pulse_ret(0);
    expect_switch(0, 32'h1800, "R5");
    @(negedge clk);
  endtask

  task automatic t_deferred();
    int n;
    opc = 32'h1A00;
    pulse_start(0);
    @(negedge clk);
    check(fl && act == 1, "R2", "flush open", {fl, act}, 2'b11);
    mr_v = 1; mr_t = 0; @(negedge clk); mr_v = 0;
    n = 1;
    for (int i = 0; i < 50 && fl; i++) begin
      check(act == 1, "R8", "no switch inside window", act, 1);
      n++;
      @(negedge clk);
    end
    check(n == FC, "R8", "first window full length", n, FC);
    check(rv && rpc == 32'h2800, "R8", "first redirect pc", rpc, 32'h2800);
    opc = 32'h2C00;
    @(negedge clk);
    check(fl && act == 0 && !rv, "R8", "deferred flush right after redirect", {fl, act, rv}, 3'b100);
    n = 0;
    for (int i = 0; i < 50 && fl; i++) begin n++; @(negedge clk); end
    check(n == FC, "R8", "second window length", n, FC);
    check(rv && rpc == 32'h1A00, "R4", "second redirect pc", rpc, 32'h1A00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_switch_away();
    t_switch_back();
    t_idle_miss_and_both_blocked();
    t_deferred();
    repeat (3) @(negedge clk);
    done = 1;
  end

  initial begin
    for (int i = 0; i < 5000 && !done; i++) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule